// File: doc/BRIEF.md
# Serial Flash Chip-Erase Command Controller

This block is the device-side command logic of a serial memory that takes commands over a four-wire serial link in SPI mode 0. While chip select is low it gathers instruction bits on rising serial clock edges. It keeps a write enable latch and runs a self-timed, chip-wide erase. The serial pins are sampled by a faster system clock, so every serial event reaches the logic after a fixed two-cycle latency.

A status-read instruction shifts out a status byte that carries the erase-busy flag and the write enable latch. An erase is committed only when four things hold: the write enable latch is set, the link is deselected exactly on an eight-bit boundary, no cycle is running and the protect input is low. A device reset pin, separate from the system reset, aborts a running erase. After that pin is released, the next selection must wait out a recovery window.

Top module: `flash_erase_ctrl`

## Requirements
- R1: Opcode 05h, after exactly eight bits, starts a status read. On each following falling serial clock edge, miso presents the next status bit, most significant first. The byte is {6'b0, WEL at bit 1, WIP at bit 0} and is repeated while select stays low. miso is 0 whenever select is high.
- R2: Opcode 06h, followed by select rising after exactly eight bits, sets the write enable latch (WEL).
- R3: Opcode C7h with WEL clear has no effect: busy stays 0.
- R4: An erase opcode is executed only when select rises right after the eighth bit. Seven bits or nine bits leave busy at 0.
- R5: An accepted erase holds busy high for exactly T_ERASE system clock cycles. At the end it pulses erase_commit for one cycle, which tells the array that every byte now reads FFh.
- R6: WEL is cleared when the erase completes.
- R7: While busy, erase and write-enable instructions are ignored and the running cycle keeps its length. Status reads still work and show WIP=1.
- R8: With prot high when select rises, an erase is ignored and WEL stays set.
- R9: Driving dev_rst_n low ends a running erase at once. busy falls, abort_pulse rises for one cycle and WEL is cleared.
- R10: After dev_rst_n returns high, a selection that begins within T_RECOVER cycles is ignored as a whole. Selections that begin later work normally.
- R11: After system reset, busy, abort_pulse, erase_commit and miso are 0, and the status byte reads 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| sck | input | 1 | Serial clock, idles low |
| cs_n | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial instruction data in |
| miso | output | 1 | Serial status data out |
| dev_rst_n | input | 1 | Active-low device reset pin; aborts erase, starts recovery |
| prot | input | 1 | High when any region is write-protected |
| busy | output | 1 | Erase in progress (the WIP flag) |
| abort_pulse | output | 1 | One-cycle pulse when a running erase is aborted |
| erase_commit | output | 1 | One-cycle pulse when an erase completes |

## Verification
The hardest state to reach is an instruction that arrives in the middle of an erase. The bench has to complete a full select, eight-bit shift and deselect while busy is high, and then show that the cycle still lasts exactly T_ERASE clocks. The bench therefore keeps T_ERASE long relative to one serial byte. It issues a status read, a write-enable and a second erase back to back inside one erase, and counts the busy cycles. The recovery window is reached in a similar way: the bench pulses the device reset during an erase and drops select on the very next cycle after release, so that the selection falls inside the window.

// File: rtl/sfe_pkg.sv
// Shared constants for the serial flash erase controller.
// Assumes 8-bit instruction codes and an 8-bit status byte.
package sfe_pkg;
    localparam int          CMD_BITS  = 8;
    localparam logic [7:0]  OP_WREN   = 8'h06;
    localparam logic [7:0]  OP_ERASE  = 8'hC7;
    localparam logic [7:0]  OP_RDSR   = 8'h05;
    localparam int          ST_WIP    = 0;
    localparam int          ST_WEL    = 1;
endpackage

// File: rtl/sfe_link_front.sv
// Pin sampler: registers the serial pins, the device reset pin and the
// protect input with the system clock, then derives one-cycle edge strobes.
// Assumes the serial clock runs at less than a quarter of the system clock.
module sfe_link_front (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    input  logic mosi,
    input  logic dev_rst_n,
    input  logic prot,
    output logic cs_fall,
    output logic cs_rise,
    output logic sck_rise,
    output logic sck_fall,
    output logic selected,
    output logic mosi_s,
    output logic pin_ok,
    output logic prot_s
);
    logic cs1, cs2, sck1, sck2, mosi1, rp1, pr1;

    // Two sample stages for select and clock, one for the level inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs1   <= 1'b1;
            cs2   <= 1'b1;
            sck1  <= 1'b0;
            sck2  <= 1'b0;
            mosi1 <= 1'b0;
            rp1   <= 1'b1;
            pr1   <= 1'b0;
        end else begin
            cs1   <= cs_n;
            cs2   <= cs1;
            sck1  <= sck;
            sck2  <= sck1;
            mosi1 <= mosi;
            rp1   <= dev_rst_n;
            pr1   <= prot;
        end
    end

    // Edge strobes; clock edges count only while selected.
    always_comb begin
        cs_fall  = ~cs1 & cs2;
        cs_rise  = cs1 & ~cs2;
        sck_rise = sck1 & ~sck2 & ~cs1;
        sck_fall = ~sck1 & sck2 & ~cs1;
        selected = ~cs1;
        mosi_s   = mosi1;
        pin_ok   = rp1;
        prot_s   = pr1;
    end
endmodule

// File: rtl/sfe_cmd_rx.sv
// Instruction receiver: counts bits in a selection, latches the opcode at
// the last bit and decides whether the selection is valid. A selection that
// begins in recovery or during device reset is invalid to its end.
module sfe_cmd_rx
    import sfe_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_fall,
    input  logic       sck_rise,
    input  logic       mosi_s,
    input  logic       pin_ok,
    input  logic       lock_active,
    output logic [7:0] opcode,
    output logic       byte_done,
    output logic       sel_ok,
    output logic       rd_active
);
    localparam int CW = $clog2(CMD_BITS + 2);

    logic [CW-1:0]       bitcnt;
    logic [CMD_BITS-2:0] shreg;

    // Bit counter (saturating past the boundary), shifter and opcode latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bitcnt <= '0;
            shreg  <= '0;
            opcode <= '0;
            sel_ok <= 1'b0;
        end else begin
            if (cs_fall) begin
                bitcnt <= '0;
                opcode <= '0;
                sel_ok <= ~lock_active & pin_ok;
            end else if (sck_rise) begin
                shreg <= {shreg[CMD_BITS-3:0], mosi_s};
                if (bitcnt == CW'(CMD_BITS - 1))
                    opcode <= {shreg, mosi_s};
                if (bitcnt != CW'(CMD_BITS + 1))
                    bitcnt <= bitcnt + 1'b1;
            end
            if (!pin_ok)
                sel_ok <= 1'b0;
        end
    end

    // Decode of the byte boundary and the status-read mode.
    always_comb begin
        byte_done = (bitcnt == CW'(CMD_BITS));
        rd_active = sel_ok && (bitcnt >= CW'(CMD_BITS)) && (opcode == OP_RDSR);
    end

    assert_lockout_rejects_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_fall && lock_active) |=> !sel_ok);
endmodule

// File: rtl/sfe_status_tx.sv
// Status shifter: during a status read, sends the live status byte MSB
// first, one bit per falling serial clock edge, and repeats it per byte.
// miso is held at 0 while deselected.
module sfe_status_tx (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       selected,
    input  logic       sck_fall,
    input  logic       rd_active,
    input  logic [7:0] status,
    output logic       miso
);
    logic [2:0] idx;
    logic [7:0] sr;

    // Loads a fresh snapshot at each byte start and shifts it out.
    always_ff @(posedge clk) begin
        if (!rst_n || !selected) begin
            idx  <= '0;
            sr   <= '0;
            miso <= 1'b0;
        end else if (sck_fall && rd_active) begin
            if (idx == 3'd0) begin
                miso <= status[7];
                sr   <= {status[6:0], 1'b0};
            end else begin
                miso <= sr[7];
                sr   <= {sr[6:0], 1'b0};
            end
            idx <= idx + 1'b1;
        end
    end

    assert_quiet_when_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !selected |=> !miso);
endmodule

// File: rtl/sfe_erase_seq.sv
// Erase sequencer: holds the write enable latch, runs the erase timer and
// the recovery window after a device reset. Instructions execute when select
// rises on a byte boundary of a valid selection; nothing but status reads
// acts while busy.
module sfe_erase_seq
    import sfe_pkg::*;
#(
    parameter int T_ERASE   = 1000,
    parameter int T_RECOVER = 100
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_rise,
    input  logic       sel_ok,
    input  logic       byte_done,
    input  logic [7:0] opcode,
    input  logic       prot_s,
    input  logic       pin_ok,
    output logic       busy,
    output logic       wel,
    output logic       abort_pulse,
    output logic       commit_pulse,
    output logic       lock_active
);
    localparam int BW = $clog2(T_ERASE + 1);
    localparam int LW = $clog2(T_RECOVER + 1);

    logic [BW-1:0] cnt;
    logic [LW-1:0] lock;
    logic          go;

    // An instruction completes on a clean deselect at the boundary.
    always_comb go = cs_rise & sel_ok & byte_done & ~busy;

    // Latch, erase timer, abort and recovery window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy         <= 1'b0;
            wel          <= 1'b0;
            cnt          <= '0;
            lock         <= '0;
            abort_pulse  <= 1'b0;
            commit_pulse <= 1'b0;
        end else if (!pin_ok) begin
            busy         <= 1'b0;
            wel          <= 1'b0;
            cnt          <= '0;
            lock         <= LW'(T_RECOVER);
            abort_pulse  <= busy;
            commit_pulse <= 1'b0;
        end else begin
            abort_pulse  <= 1'b0;
            commit_pulse <= 1'b0;
            if (lock != '0)
                lock <= lock - 1'b1;
            if (busy) begin
                if (cnt == '0) begin
                    busy         <= 1'b0;
                    wel          <= 1'b0;
                    commit_pulse <= 1'b1;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end else if (go) begin
                if (opcode == OP_WREN)
                    wel <= 1'b1;
                else if (opcode == OP_ERASE && wel && !prot_s) begin
                    busy <= 1'b1;
                    cnt  <= BW'(T_ERASE - 1);
                end
            end
        end
    end

    always_comb lock_active = (lock != '0);

    assert_abort_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_ok |=> (!busy && !wel));
    assert_erase_needs_wel_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wel));
    assert_wel_drops_at_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        commit_pulse |-> (!wel && !busy));
    assert_timer_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cnt <= BW'(T_ERASE - 1)));
    assert_protect_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (go && opcode == OP_ERASE && prot_s) |=> (!busy && $stable(wel)));
endmodule

// File: rtl/flash_erase_ctrl.sv
// Top of the serial flash erase controller: pin sampler, instruction
// receiver, status shifter and erase sequencer. Assumes SPI mode 0 and a
// system clock at least four times the serial clock.
module flash_erase_ctrl
    import sfe_pkg::*;
#(
    parameter int T_ERASE   = 1000000,
    parameter int T_RECOVER = 3000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    input  logic mosi,
    output logic miso,
    input  logic dev_rst_n,
    input  logic prot,
    output logic busy,
    output logic abort_pulse,
    output logic erase_commit
);
    logic       cs_fall, cs_rise, sck_rise, sck_fall, selected;
    logic       mosi_s, pin_ok, prot_s;
    logic [7:0] opcode;
    logic       byte_done, sel_ok, rd_active;
    logic       wel, lock_active;
    logic [7:0] status;

    sfe_link_front u_front (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi),
        .dev_rst_n(dev_rst_n), .prot(prot),
        .cs_fall(cs_fall), .cs_rise(cs_rise), .sck_rise(sck_rise),
        .sck_fall(sck_fall), .selected(selected), .mosi_s(mosi_s),
        .pin_ok(pin_ok), .prot_s(prot_s)
    );

    sfe_cmd_rx u_rx (
        .clk(clk), .rst_n(rst_n), .cs_fall(cs_fall), .sck_rise(sck_rise),
        .mosi_s(mosi_s), .pin_ok(pin_ok), .lock_active(lock_active),
        .opcode(opcode), .byte_done(byte_done), .sel_ok(sel_ok),
        .rd_active(rd_active)
    );

    // Live status byte assembled from the sequencer flags.
    always_comb begin
        status         = '0;
        status[ST_WIP] = busy;
        status[ST_WEL] = wel;
    end

    sfe_status_tx u_tx (
        .clk(clk), .rst_n(rst_n), .selected(selected), .sck_fall(sck_fall),
        .rd_active(rd_active), .status(status), .miso(miso)
    );

    sfe_erase_seq #(.T_ERASE(T_ERASE), .T_RECOVER(T_RECOVER)) u_seq (
        .clk(clk), .rst_n(rst_n), .cs_rise(cs_rise), .sel_ok(sel_ok),
        .byte_done(byte_done), .opcode(opcode), .prot_s(prot_s),
        .pin_ok(pin_ok), .busy(busy), .wel(wel), .abort_pulse(abort_pulse),
        .commit_pulse(erase_commit), .lock_active(lock_active)
    );
endmodule

// File: tb/test_flash_erase_ctrl.sv
// Bench: drives the serial link from tasks and compares the ports against
// a behavioural model evaluated on every clock.
module test_flash_erase_ctrl;
    localparam int TBE = 400;
    localparam int TRH = 20;
    localparam int H   = 3;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n = 1'b0, sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic dev_rst_n = 1'b1, prot = 1'b0;
    logic miso, busy, abort_pulse, erase_commit;

    flash_erase_ctrl #(.T_ERASE(TBE), .T_RECOVER(TRH)) i_flash_erase_ctrl (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi),
        .miso(miso), .dev_rst_n(dev_rst_n), .prot(prot), .busy(busy),
        .abort_pulse(abort_pulse), .erase_commit(erase_commit)
    );

    int n_cmp = 0, n_bad = 0, cyc = 0;
    int busy_cyc = 0, commit_cnt = 0, abort_cnt = 0;
    bit cmp_en = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Behavioural model: acts on the pins one clock ahead of the design.
    bit p_cs = 1, p_sck = 0;
    int m_bits = 0, m_op = 0, m_sr = 0, m_cnt = 0, m_lock = 0;
    bit m_sel = 0, m_wel = 0, m_busy = 0, m_abort = 0, m_commit = 0;
    bit d_busy = 0, d_abort = 0, d_commit = 0;

    always @(posedge clk) begin
        bit cf, cr, sr_e;
        int o_lock;
        d_busy = m_busy; d_abort = m_abort; d_commit = m_commit;
        if (!rst_n) begin
            m_bits = 0; m_op = 0; m_sr = 0; m_cnt = 0; m_lock = 0;
            m_sel = 0; m_wel = 0; m_busy = 0; m_abort = 0; m_commit = 0;
        end else begin
            cf = p_cs && !cs_n;
            cr = !p_cs && cs_n;
            sr_e = !cs_n && sck && !p_sck;
            o_lock = m_lock;
            if (!dev_rst_n) begin
                m_abort = m_busy; m_commit = 0;
                m_busy = 0; m_wel = 0; m_lock = TRH;
            end else begin
                m_abort = 0; m_commit = 0;
                if (m_lock > 0) m_lock--;
                if (m_busy) begin
                    if (m_cnt == 0) begin m_busy = 0; m_wel = 0; m_commit = 1; end
                    else m_cnt--;
                end else if (cr && m_sel && m_bits == 8) begin
                    if (m_op == 'h06) m_wel = 1;
                    else if (m_op == 'hC7 && m_wel && !prot) begin
                        m_busy = 1; m_cnt = TBE - 1;
                    end
                end
            end
            if (cf) begin
                m_bits = 0; m_op = 0; m_sel = (o_lock == 0) && dev_rst_n;
            end else if (sr_e) begin
                m_sr = ((m_sr << 1) | mosi) & 'hFF;
                if (m_bits == 7) m_op = m_sr;
                if (m_bits < 9) m_bits++;
            end
            if (!dev_rst_n) m_sel = 0;
        end
        p_cs = cs_n; p_sck = sck;
    end

    // Per-clock comparison, event counters and watchdog.
    always @(negedge clk) begin
        cyc++;
        if (rst_n && cmp_en) begin
            chk(busy === d_busy, "R5 busy", busy, d_busy);
            chk(abort_pulse === d_abort, "R9 abort_pulse", abort_pulse, d_abort);
            chk(erase_commit === d_commit, "R5 erase_commit", erase_commit, d_commit);
        end
        if (busy === 1'b1) busy_cyc++;
        if (erase_commit === 1'b1) commit_cnt++;
        if (abort_pulse === 1'b1) abort_cnt++;
        if (cyc > 200000) begin
            chk(0, "watchdog", cyc, 200000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sel();
        @(negedge clk); cs_n = 1'b0; idle(H);
    endtask

    task automatic desel();
        idle(H); cs_n = 1'b1; idle(H);
    endtask

    task automatic shift_bits(input logic [15:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            mosi = v[i]; idle(H); sck = 1'b1; idle(H); sck = 1'b0;
        end
    endtask

    task automatic cmd(input logic [7:0] op);
        sel(); shift_bits({8'h00, op}, 8); desel();
    endtask

    task automatic chk_status(input logic [7:0] exp, input string tag);
        logic [7:0] got;
        sel(); shift_bits(16'h0005, 8);
        got = '0;
        for (int i = 0; i < 8; i++) begin
            idle(H); got = {got[6:0], miso}; sck = 1'b1; idle(H); sck = 1'b0;
        end
        desel();
        chk(got === exp, tag, got, exp);
    endtask

    initial begin
        idle(4); rst_n = 1'b1; idle(2); cmp_en = 1;
        // R11: reset state at the ports and in the status byte
        chk(busy === 0 && abort_pulse === 0 && erase_commit === 0, "R11 outputs", busy, 0);
        chk(miso === 0, "R11 miso", miso, 0);
        chk_status(8'h00, "R11 R1 status after reset");
        // R3: erase with WEL clear
        cmd(8'hC7); idle(10);
        chk(busy === 0, "R3 erase without WEL", busy, 0);
        // R2: write enable
        cmd(8'h06);
        chk_status(8'h02, "R2 R1 WEL set");
        // R4: seven and nine bits
        sel(); shift_bits(16'h0063, 7); desel(); idle(10);
        chk(busy === 0, "R4 seven bits", busy, 0);
        sel(); shift_bits(16'h018E, 9); desel(); idle(10);
        chk(busy === 0, "R4 nine bits", busy, 0);
        // R8: protected
        prot = 1'b1; cmd(8'hC7); idle(10);
        chk(busy === 0, "R8 protected erase", busy, 0);
        chk_status(8'h02, "R8 WEL kept");
        prot = 1'b0;
        // R5 R7 R6: full erase with instructions issued during it
        busy_cyc = 0; commit_cnt = 0;
        cmd(8'hC7);
        chk(busy === 1, "R5 erase started", busy, 1);
        chk_status(8'h03, "R7 R1 status while busy");
        cmd(8'h06); cmd(8'hC7);
        while (busy === 1'b1) idle(1);
        idle(3);
        chk(busy_cyc == TBE, "R5 R7 busy length", busy_cyc, TBE);
        chk(commit_cnt == 1, "R5 commit pulses", commit_cnt, 1);
        chk_status(8'h00, "R6 WEL cleared");
        // R9 R10: abort and recovery window
        cmd(8'h06); cmd(8'hC7); idle(10);
        chk(busy === 1, "R9 erase running", busy, 1);
        abort_cnt = 0;
        dev_rst_n = 1'b0; idle(3); dev_rst_n = 1'b1;
        chk(busy === 0, "R9 busy dropped", busy, 0);
        chk(abort_cnt == 1, "R9 abort pulse", abort_cnt, 1);
        cmd(8'h06);
        chk_status(8'h00, "R10 R9 select in recovery ignored");
        cmd(8'h06);
        chk_status(8'h02, "R10 select after recovery");
        idle(5);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule